// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the byte-wide, memory-mapped control face of a small UART. A simple strobe bus (separate write and read strobes, an 8-bit address and byte data) reaches the port's registers: a global on/off switch, a control register with receive/transmit enables and a soft reset, the line status, the line configuration, a 16-bit baud divisor, the FIFO status and configuration, and four interrupt registers. Writing the data address loads a byte into a 16-entry transmit queue. Reading the data address takes a byte from a 16-entry receive queue.

The serial shifters sit outside the block. The transmit engine sees a "byte available" output and the head byte, and takes a byte with a one-cycle pop pulse. The receive engine delivers a byte with a one-cycle push pulse, along with parity and framing error flags. The divisor and line configuration leave the block as plain outputs.

Two interrupt sources, transmit and receive, are each held in a flag. A flag is raised by a hardware event or by software through a set register, and cleared through a write-one-to-clear register. The single interrupt line is the OR of the enabled flags. The set register lets a polling routine force a receive interrupt when the queue holds fewer bytes than the hardware threshold.

Top module: `uart_regfront`

## Requirements
- R1: After reset every register reads 0, except that FIFO status (0x0a) reads 0x04 and line status (0x02) reads 0x40. The irq and tx_avail outputs are 0.
- R2: These registers read back what was written: enable 0x00 (bit 0), control 0x01 (bits 2:0), line config 0x03, divisor low 0x08, divisor high 0x09, FIFO config 0x0b and interrupt enable 0x1e (bits 1:0). The divisor drives baud_div and the line config drives line_cfg. Reading any unmapped address returns 0.
- R3: A write to 0x04 appends a byte to the 16-deep transmit queue, and the queue emits bytes in order. When the queue is full, FIFO status bit 4 reads 1 and a further write is dropped.
- R4: A read of 0x04 returns the oldest received byte and removes it. A read of 0x04 while the receive queue is empty returns 0 and leaves the queue unchanged. Read data appears on bus_rdata the cycle after the read strobe. FIFO status bit 2 is 1 while the receive queue is empty.
- R5: Line status bits hold sticky errors: bit 0 is parity, bit 1 is framing, and bit 2 is overrun. An overrun is a push into a full receive queue, and that byte is lost. The parity and framing bits are taken from rx_err[0] and rx_err[1] on each accepted push.
- R6: Line status bit 6 reads 1 only when the transmit queue is empty and tx_busy is 0.
- R7: In every interrupt register, bit 0 is transmit and bit 1 is receive. Writing a 1 to a bit of 0x1d raises that flag. Reading 0x1f returns the raw flags, whatever the enable register holds.
- R8: Writing a 1 to a bit of 0x1c lowers that flag, and writing 0x03 lowers both. A hardware event in the same cycle as the clear leaves its flag raised.
- R9: irq is 1 exactly when some flag is 1 and its enable bit in 0x1e is 1.
- R10: The receive flag rises on the push that brings the receive queue to 8 plus FIFO config bits 2:0 (capped at 16). The transmit flag rises on the pop that empties the transmit queue.
- R11: Writing control bit 2 empties both queues, lowers both flags and clears the error bits at once. This state holds until the bit is written back to 0. The divisor, line config and FIFO config registers are kept.
- R12: Receive pushes are accepted only while enable bit 0 and control bit 0 are both 1. tx_avail is 1 only while enable bit 0 and control bit 1 are both 1, the transmit queue is not empty and soft reset is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| tx_avail | output | 1 | A transmit byte is available to the engine |
| tx_data | output | 8 | Head of the transmit queue |
| tx_pop | input | 1 | Engine takes the head byte |
| tx_busy | input | 1 | Transmit shifter is still sending |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 2 | Receive errors: bit 0 parity, bit 1 framing |
| baud_div | output | 16 | Baud divisor for the engines |
| line_cfg | output | 8 | Line configuration for the engines |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume strobe-level inputs: at most one of bus_wr and bus_rd is high in a cycle, and rx_push and tx_pop are one-cycle pulses. They also assume the engine pops only while tx_avail is 1. The property on full-queue writes further assumes no pop in that same cycle. The stimulus drives every bus access and engine pulse from tasks that raise a strobe for exactly one cycle. It pops the transmit queue only after checking tx_avail. It never overlaps a bus read with a bus write. The only deliberate overlap is a receive push in the same cycle as a flag-clear write, which the assertions allow.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam logic [7:0] A_ENABLE = 8'h00;
    localparam logic [7:0] A_CTRL   = 8'h01;
    localparam logic [7:0] A_LSTAT  = 8'h02;
    localparam logic [7:0] A_LCFG   = 8'h03;
    localparam logic [7:0] A_DATA   = 8'h04;
    localparam logic [7:0] A_DIVLO  = 8'h08;
    localparam logic [7:0] A_DIVHI  = 8'h09;
    localparam logic [7:0] A_FSTAT  = 8'h0A;
    localparam logic [7:0] A_FCFG   = 8'h0B;
    localparam logic [7:0] A_FCLR   = 8'h1C;
    localparam logic [7:0] A_FSET   = 8'h1D;
    localparam logic [7:0] A_IEN    = 8'h1E;
    localparam logic [7:0] A_ISTAT  = 8'h1F;

    localparam int IRQ_TX = 0;
    localparam int IRQ_RX = 1;

    localparam int CTL_RXEN = 0;
    localparam int CTL_TXEN = 1;
    localparam int CTL_SRST = 2;

    typedef struct packed {
        logic        en;
        logic [2:0]  ctrl;
        logic [7:0]  lcfg;
        logic [15:0] div;
        logic [7:0]  fcfg;
        logic [2:0]  err;
        logic [1:0]  ie;
        logic [7:0]  rdata;
    } regs_t;

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == LAST) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
            if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
            else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ien,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        if (flush) flags_d = '0;
        else       flags_d = (flags_q & ~sw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & ien);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        tx_avail,
    output logic [7:0]  tx_data,
    input  logic        tx_pop,
    input  logic        tx_busy,
    input  logic        rx_push,
    input  logic [7:0]  rx_data,
    input  logic [1:0]  rx_err,
    output logic [15:0] baud_div,
    output logic [7:0]  line_cfg,
    output logic        irq
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    regs_t q, d;

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    rx_dout;
    logic [1:0]    flags, ien, sw_set, sw_clr, hw_set;
    logic [2:0]    err;
    logic          srst, rx_ok, overrun, bus_pop, tx_push, tx_pop_ok;
    logic          rx_hw, tx_hw, drained;
    logic [CW:0]   lvl_sum;
    logic [CW-1:0] lvl;
    logic [7:0]    rd_mux;

    // soft reset acts in the cycle it is written and while it is held
    assign srst = q.ctrl[CTL_SRST] || (bus_wr && bus_addr == A_CTRL && bus_wdata[CTL_SRST]);

    assign rx_ok     = rx_push && q.en && q.ctrl[CTL_RXEN] && !srst;
    assign overrun   = rx_ok && rx_full;
    assign bus_pop   = bus_rd && bus_addr == A_DATA && !rx_empty && !srst;
    assign tx_push   = bus_wr && bus_addr == A_DATA && !srst;
    assign tx_avail  = q.en && q.ctrl[CTL_TXEN] && !tx_empty && !q.ctrl[CTL_SRST];
    assign tx_pop_ok = tx_pop && tx_avail && !srst;
    assign drained   = tx_empty && !tx_busy;

    // receive threshold: half depth plus the 3-bit config field, capped at depth
    assign lvl_sum = (CW+1)'(HALF) + (CW+1)'(q.fcfg[2:0]);
    assign lvl     = (lvl_sum > (CW+1)'(DEPTH)) ? CW'(DEPTH) : lvl_sum[CW-1:0];

    assign rx_hw = rx_ok && !rx_full && !bus_pop && (rx_cnt == lvl - 1'b1);
    assign tx_hw = tx_pop_ok && (tx_cnt == CW'(1)) && !tx_push;

    assign hw_set = {rx_hw, tx_hw};
    assign sw_set = (bus_wr && bus_addr == A_FSET) ? bus_wdata[1:0] : 2'b00;
    assign sw_clr = (bus_wr && bus_addr == A_FCLR) ? bus_wdata[1:0] : 2'b00;
    assign ien    = q.ie;
    assign err    = q.err;

    uart_rf_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(srst),
        .push(tx_push), .din(bus_wdata),
        .pop(tx_pop_ok), .dout(tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    uart_rf_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(srst),
        .push(rx_ok), .din(rx_data),
        .pop(bus_pop), .dout(rx_dout),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    uart_rf_irq #(.N(2)) u_irq (
        .clk(clk), .rst_n(rst_n), .flush(srst),
        .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr),
        .ien(ien), .flags(flags), .irq(irq)
    );

    always_comb begin
        case (bus_addr)
            A_ENABLE: rd_mux = {7'd0, q.en};
            A_CTRL:   rd_mux = {5'd0, q.ctrl};
            A_LSTAT:  rd_mux = {1'b0, drained, 3'd0, q.err};
            A_LCFG:   rd_mux = q.lcfg;
            A_DATA:   rd_mux = (rx_empty || srst) ? 8'h00 : rx_dout;
            A_DIVLO:  rd_mux = q.div[7:0];
            A_DIVHI:  rd_mux = q.div[15:8];
            A_FSTAT:  rd_mux = {3'd0, tx_full, 1'b0, rx_empty, 2'd0};
            A_FCFG:   rd_mux = q.fcfg;
            A_IEN:    rd_mux = {6'd0, q.ie};
            A_ISTAT:  rd_mux = {6'd0, flags};
            default:  rd_mux = 8'h00;
        endcase
    end

    always_comb begin
        d = q;
        if (bus_wr) begin
            case (bus_addr)
                A_ENABLE: d.en        = bus_wdata[0];
                A_CTRL:   d.ctrl      = bus_wdata[2:0];
                A_LCFG:   d.lcfg      = bus_wdata;
                A_DIVLO:  d.div[7:0]  = bus_wdata;
                A_DIVHI:  d.div[15:8] = bus_wdata;
                A_FCFG:   d.fcfg      = bus_wdata;
                A_IEN:    d.ie        = bus_wdata[1:0];
                default:  ;
            endcase
        end
        if (srst) begin
            d.err = '0;
        end else begin
            if (overrun) d.err[2] = 1'b1;
            if (rx_ok)   d.err[1:0] = q.err[1:0] | rx_err;
        end
        if (bus_rd) d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign baud_div  = q.div;
    assign line_cfg  = q.lcfg;

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [7:0]    bus_addr,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic          tx_pop,
    input logic          tx_busy,
    input logic          rx_push,
    input logic          irq,
    input logic          port_on,
    input logic [2:0]    ctrl,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [1:0]    flags,
    input logic [1:0]    ien,
    input logic [2:0]    err
);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & ien) != 2'b00));

    // R5
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && port_on && ctrl[CTL_RXEN] && !ctrl[CTL_SRST]
         && !(bus_wr && bus_addr == A_CTRL) && rx_cnt == CW'(DEPTH)) |=> err[2]);

    // R3
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && tx_cnt == CW'(DEPTH) && !tx_pop) |=> tx_cnt == CW'(DEPTH));

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA && rx_cnt == '0) |=> bus_rdata == 8'h00);

    // R11
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[CTL_SRST])
        |=> (flags == 2'b00 && tx_cnt == '0 && rx_cnt == '0 && err == 3'b000));

    // R7
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FSET && !ctrl[CTL_SRST])
        |=> ((flags & $past(bus_wdata[1:0])) == $past(bus_wdata[1:0])));

    // R6
    drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LSTAT && (tx_cnt != '0 || tx_busy)) |=> !bus_rdata[6]);

endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pop(tx_pop), .tx_busy(tx_busy), .rx_push(rx_push), .irq(irq),
    .port_on(q.en), .ctrl(q.ctrl), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .flags(flags), .ien(ien), .err(err)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
    import uart_rf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        tx_avail;
    logic [7:0]  tx_data;
    logic        tx_pop = 1'b0, tx_busy = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [1:0]  rx_err = 2'b00;
    logic [15:0] baud_div;
    logic [7:0]  line_cfg;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [7:0] qexp[$];
    string      qtag[$];

    always #4 clk = ~clk;

    uart_regfront u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_avail(tx_avail), .tx_data(tx_data), .tx_pop(tx_pop), .tx_busy(tx_busy),
        .rx_push(rx_push), .rx_data(rx_data), .rx_err(rx_err),
        .baud_div(baud_div), .line_cfg(line_cfg), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares read data the cycle after each read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd && rst_n) begin
                #1;
                if (qexp.size() == 0) begin
                    chk("scoreboard underflow", 16'h1, 16'h0);
                end else begin
                    chk(qtag.pop_front(), {8'h00, bus_rdata}, {8'h00, qexp.pop_front()});
                end
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        qexp.push_back(exp); qtag.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] v, input logic [1:0] e);
        @(negedge clk);
        rx_push = 1'b1; rx_data = v; rx_err = e;
        @(negedge clk);
        rx_push = 1'b0; rx_err = 2'b00;
    endtask

    task automatic tx_take(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tag, tx_avail, 1'b1);
        chk(tag, tx_data, exp);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        chk("watchdog expired", 16'h1, 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 1'b0);
        chk("R1 tx_avail", tx_avail, 1'b0);
        rd_reg(A_FSTAT, 8'h04, "R1 fifo status");
        rd_reg(A_LSTAT, 8'h40, "R1 line status");
        rd_reg(A_LCFG, 8'h00, "R1 line cfg");
        rd_reg(A_ISTAT, 8'h00, "R1 int status");

        // R2 plain registers
        wr_reg(A_LCFG, 8'h13);
        wr_reg(A_DIVLO, 8'h34);
        wr_reg(A_DIVHI, 8'h12);
        chk("R2 baud_div", baud_div, 16'h1234);
        chk("R2 line_cfg", line_cfg, 16'h0013);
        rd_reg(A_DIVLO, 8'h34, "R2 div lo");
        rd_reg(A_DIVHI, 8'h12, "R2 div hi");
        rd_reg(8'h05, 8'h00, "R2 unmapped");
        wr_reg(A_FCFG, 8'h8F);
        rd_reg(A_FCFG, 8'h8F, "R2 fifo cfg");
        wr_reg(A_ENABLE, 8'h01);
        wr_reg(A_CTRL, 8'h03);
        rd_reg(A_ENABLE, 8'h01, "R2 enable");
        rd_reg(A_CTRL, 8'h03, "R2 ctrl");

        // R3 / R6 / R10 / R9 transmit path
        wr_reg(A_DATA, 8'hA1);
        wr_reg(A_DATA, 8'hA2);
        tx_busy = 1'b1;
        rd_reg(A_LSTAT, 8'h00, "R6 not drained");
        tx_take(8'hA1, "R3 first byte");
        tx_take(8'hA2, "R3 second byte");
        rd_reg(A_ISTAT, 8'h01, "R10 tx flag on empty");
        chk("R9 masked irq", irq, 1'b0);
        wr_reg(A_IEN, 8'h01);
        chk("R9 enabled irq", irq, 1'b1);
        wr_reg(A_FCLR, 8'h01);
        chk("R8 tx clear irq", irq, 1'b0);
        rd_reg(A_ISTAT, 8'h00, "R8 tx cleared");
        rd_reg(A_LSTAT, 8'h00, "R6 shifter busy");
        tx_busy = 1'b0;
        rd_reg(A_LSTAT, 8'h40, "R6 drained");

        // R3 full queue drops extra write
        for (int i = 0; i < 16; i++) wr_reg(A_DATA, 8'h10 + 8'(i));
        rd_reg(A_FSTAT, 8'h14, "R3 tx full status");
        wr_reg(A_DATA, 8'hEE);
        for (int i = 0; i < 16; i++) tx_take(8'h10 + 8'(i), "R3 full order");
        chk("R3 dropped byte absent", tx_avail, 1'b0);
        wr_reg(A_FCLR, 8'h01);

        // R4 receive read
        rd_reg(A_DATA, 8'h00, "R4 empty read");
        rd_reg(A_FSTAT, 8'h04, "R4 still empty");
        rx_byte(8'h5A, 2'b00);
        rd_reg(A_FSTAT, 8'h00, "R4 not empty");
        rd_reg(A_DATA, 8'h5A, "R4 read byte");
        rd_reg(A_FSTAT, 8'h04, "R4 empty again");

        // R10 receive threshold (level 8)
        wr_reg(A_IEN, 8'h00);
        wr_reg(A_FCFG, 8'h88);
        for (int i = 0; i < 7; i++) rx_byte(8'h40 + 8'(i), 2'b00);
        rd_reg(A_ISTAT, 8'h00, "R10 below level");
        rx_byte(8'h47, 2'b00);
        rd_reg(A_ISTAT, 8'h02, "R10 rx flag at level");
        wr_reg(A_IEN, 8'h02);
        chk("R9 rx irq", irq, 1'b1);
        for (int i = 0; i < 8; i++) rd_reg(A_DATA, 8'h40 + 8'(i), "R4 rx order");
        wr_reg(A_FCLR, 8'h02);
        chk("R8 rx clear irq", irq, 1'b0);

        // R7 / R8 software set and clear
        wr_reg(A_FSET, 8'h02);
        rd_reg(A_ISTAT, 8'h02, "R7 forced rx");
        chk("R7 forced irq", irq, 1'b1);
        wr_reg(A_FSET, 8'h01);
        rd_reg(A_ISTAT, 8'h03, "R7 forced both");
        wr_reg(A_IEN, 8'h00);
        chk("R9 all masked", irq, 1'b0);
        rd_reg(A_ISTAT, 8'h03, "R7 raw flags");
        wr_reg(A_FCLR, 8'h03);
        rd_reg(A_ISTAT, 8'h00, "R8 clear both");

        // R8 hardware event wins over clear in same cycle
        for (int i = 0; i < 7; i++) rx_byte(8'h50 + 8'(i), 2'b00);
        @(negedge clk);
        rx_push = 1'b1; rx_data = 8'h57;
        bus_wr = 1'b1; bus_addr = A_FCLR; bus_wdata = 8'h02;
        @(negedge clk);
        rx_push = 1'b0; bus_wr = 1'b0;
        rd_reg(A_ISTAT, 8'h02, "R8 event beats clear");
        for (int i = 0; i < 8; i++) rd_reg(A_DATA, 8'h50 + 8'(i), "R8 data order");
        wr_reg(A_FCLR, 8'h02);

        // R5 errors and overrun
        for (int i = 0; i < 16; i++)
            rx_byte(8'h30 + 8'(i), (i == 3) ? 2'b01 : ((i == 5) ? 2'b10 : 2'b00));
        rx_byte(8'hFF, 2'b00);
        rd_reg(A_LSTAT, 8'h47, "R5 sticky errors");
        for (int i = 0; i < 16; i++) rd_reg(A_DATA, 8'h30 + 8'(i), "R5 overrun byte lost");
        rd_reg(A_DATA, 8'h00, "R5 queue empty after drain");

        // R11 soft reset
        wr_reg(A_DATA, 8'h11);
        wr_reg(A_DATA, 8'h22);
        rx_byte(8'h99, 2'b00);
        wr_reg(A_FSET, 8'h03);
        wr_reg(A_IEN, 8'h03);
        chk("R11 irq before", irq, 1'b1);
        wr_reg(A_CTRL, 8'h04);
        chk("R11 irq after", irq, 1'b0);
        chk("R11 tx_avail after", tx_avail, 1'b0);
        wr_reg(A_CTRL, 8'h03);
        rd_reg(A_FSTAT, 8'h04, "R11 queues empty");
        rd_reg(A_ISTAT, 8'h00, "R11 flags low");
        rd_reg(A_LSTAT, 8'h40, "R11 errors cleared");
        rd_reg(A_LCFG, 8'h13, "R11 cfg kept");
        rd_reg(A_FCFG, 8'h88, "R11 fifo cfg kept");
        chk("R11 divisor kept", baud_div, 16'h1234);

        // R12 enable gating
        wr_reg(A_IEN, 8'h00);
        wr_reg(A_ENABLE, 8'h00);
        rx_byte(8'h66, 2'b00);
        rd_reg(A_FSTAT, 8'h04, "R12 rx blocked when off");
        wr_reg(A_DATA, 8'h77);
        chk("R12 tx_avail off", tx_avail, 1'b0);
        rd_reg(A_LSTAT, 8'h00, "R6 queue holds byte");
        wr_reg(A_ENABLE, 8'h01);
        tx_take(8'h77, "R12 tx after enable");
        wr_reg(A_CTRL, 8'h02);
        rx_byte(8'h68, 2'b00);
        rd_reg(A_FSTAT, 8'h04, "R12 rx blocked by ctrl");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 16'(qexp.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule